// File: doc/BRIEF.md
# Transport Stream PID Bitmap Filter

This block passes or discards whole MPEG transport stream packets according to a per-PID bitmap. It holds `NUM_FILT` independent filter lanes (two by default). Each lane has its own byte stream input and output, its own 1024-byte table with one bit per 13-bit PID, and its own counter of packets that arrived without a valid sync byte. A set table bit blocks that PID. A clear bit lets it through. PIDs below 0x20 are never blocked.

Each lane reads the PID from header bytes 1 and 2 while the bytes travel through a short delay line. It looks the PID up in its table and latches a keep or drop verdict before byte 0 reaches the output. The verdict then gates the output valid for every byte of that packet. A host reaches the tables indirectly through three registers: a low index register, a high index register that also selects the filter, and a data register. Reading the data register returns the selected table byte, so the host can change a single bit with a read-modify-write.

Top module: `ts_pid_gate`

## Requirements
- R1: Host register select codes are 0 for the low index register, 1 for the high index register and 2 for the data register. The low index register holds PID[10:3] in all 8 bits. The high index register keeps only bits 2:0: bits 1:0 hold PID[12:11] and bit 2 selects the filter. Reading either register returns its contents, with unused high bits read as zero, on `host_rdata` in the cycle after `host_rd`.
- R2: A host write to the data register stores the byte at table byte index {high[1:0], low[7:0]} of the filter chosen by high[2]. A host read of the data register returns that table byte in the cycle after `host_rd`.
- R3: The PID of a packet is {byte1[4:0], byte2}. The upper three bits of byte 1 are ignored. Its table bit is bit PID[2:0] of table byte PID[12:3]. When that bit is 1, no byte of the packet is output. When it is 0, all bytes are output. Header bytes 0 to 2 arrive in consecutive valid cycles, and packet starts are at least 4 cycles apart.
- R4: A packet whose PID is 0x00 to 0x1F passes whatever the contents of table bytes 0 to 3.
- R5: A packet whose first byte (marked by `in_sop`) is not 0x47 is dropped whole. That lane's resync counter increases by one in the cycle after the start byte is sampled, and it is otherwise unchanged.
- R6: A passed byte sampled on clock edge k appears on `out_data` after edge k+3. Its data is unchanged, and `out_sop` marks byte 0. Gaps in `in_valid` after byte 2 are reproduced on the output.
- R7: The lanes are independent. Table writes to one filter change neither the other filter's table nor the other lane's output.
- R8: After reset, all output valids and sop flags are 0, resync counters are 0, both index registers are 0 and `host_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_sel | input | 2 | Host register select (0 low index, 1 high index, 2 data) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid the cycle after `host_rd` |
| in_valid | input | NUM_FILT | Per-lane input byte valid |
| in_sop | input | NUM_FILT | Per-lane packet start marker on byte 0 |
| in_data | input | 8*NUM_FILT | Per-lane input bytes, lane f at bits [8f+7:8f] |
| out_valid | output | NUM_FILT | Per-lane output byte valid, low for dropped packets |
| out_sop | output | NUM_FILT | Per-lane output packet start |
| out_data | output | 8*NUM_FILT | Per-lane output bytes |
| resync_cnt | output | CNT_W*NUM_FILT | Per-lane count of packets with a bad sync byte |

## Verification
The stream is driven with random packets on both lanes at once. Some PIDs are drawn from a small pool whose table bits the bench has set. Others span the full 13-bit range. Random bits above the PID field in byte 1 and random mid-packet gaps show whether the verdict follows only the PID bits and whether pass-through keeps exact timing.

Directed patterns cover further cases:
- PIDs in one table byte that differ only in the bit index, which separates byte addressing from bit selection.
- The same PID blocked in one filter and open in the other, which shows the lanes are independent.
- Low PIDs with table bytes 0 to 3 all ones, which checks the always-pass rule.
- A table with every upper byte all ones, which checks block-all mode.
- Occasional corrupted sync bytes, which check whole-packet drop and the resync count.

// File: rtl/tspf_pkg.sv
package tspf_pkg;
  localparam int PID_W      = 13;
  localparam int BIT_W      = 3;
  localparam int IDX_W      = PID_W - BIT_W;
  localparam int PASS_LIMIT = 32;
  localparam logic [7:0] SYNC_BYTE = 8'h47;

  typedef enum logic [1:0] {
    REG_IDX_LO = 2'd0,
    REG_IDX_HI = 2'd1,
    REG_BITS   = 2'd2,
    REG_NONE   = 2'd3
  } host_reg_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_B1   = 2'd1,
    PH_B2   = 2'd2
  } hdr_ph_e;

  // PID field spans the low five bits of header byte 1 and all of byte 2
  function automatic logic [PID_W-1:0] pid_from_hdr(input logic [7:0] b1,
                                                    input logic [7:0] b2);
    return {b1[4:0], b2};
  endfunction

  function automatic logic pid_always_pass(input logic [PID_W-1:0] pid);
    return pid < PID_W'(PASS_LIMIT);
  endfunction

  function automatic logic bit_blocked(input logic [7:0] row,
                                       input logic [BIT_W-1:0] pos);
    return row[pos];
  endfunction
endpackage

// File: rtl/tspf_bitmap_ram.sv
module tspf_bitmap_ram #(
  parameter int IDX_W = 10,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             a_we,
  input  logic             a_re,
  input  logic [IDX_W-1:0] a_addr,
  input  logic [DW-1:0]    a_wdata,
  output logic [DW-1:0]    a_q,
  input  logic             b_re,
  input  logic [IDX_W-1:0] b_addr,
  output logic [DW-1:0]    b_q
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];

  // host port: write plus registered read
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (a_re) a_q <= mem[a_addr];
  end

  // stream port: registered read only
  always_ff @(posedge clk) begin
    if (b_re) b_q <= mem[b_addr];
  end
endmodule

// File: rtl/tspf_host.sv
module tspf_host
  import tspf_pkg::*;
#(
  parameter int NUM_FILT = 2,
  parameter int FSEL_W   = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_wr,
  input  logic                   host_rd,
  input  logic [1:0]             host_sel,
  input  logic [7:0]             host_wdata,
  output logic [7:0]             host_rdata,
  output logic [IDX_W-1:0]       ram_addr,
  output logic [7:0]             ram_wdata,
  output logic [NUM_FILT-1:0]    ram_we,
  output logic [NUM_FILT-1:0]    ram_re,
  input  logic [NUM_FILT*8-1:0]  ram_q
);
  localparam int HI_IDX_W = IDX_W - 8;
  localparam int HI_W     = HI_IDX_W + FSEL_W;

  host_reg_e         sel_e;
  logic [7:0]        idx_lo;
  logic [HI_W-1:0]   idx_hi;
  logic [FSEL_W-1:0] sel_f;
  logic              rd_from_ram;
  logic [FSEL_W-1:0] rd_filt;
  logic [7:0]        rd_reg;

  assign sel_e     = host_reg_e'(host_sel);
  assign sel_f     = idx_hi[HI_W-1 -: FSEL_W];
  assign ram_addr  = {idx_hi[HI_IDX_W-1:0], idx_lo};
  assign ram_wdata = host_wdata;

  for (genvar g = 0; g < NUM_FILT; g++) begin : g_port
    assign ram_we[g] = host_wr && (sel_e == REG_BITS) && (sel_f == FSEL_W'(g));
    assign ram_re[g] = host_rd && (sel_e == REG_BITS) && (sel_f == FSEL_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_lo      <= '0;
      idx_hi      <= '0;
      rd_from_ram <= 1'b0;
      rd_filt     <= '0;
      rd_reg      <= '0;
    end else begin
      if (host_wr) begin
        case (sel_e)
          REG_IDX_LO: idx_lo <= host_wdata;
          REG_IDX_HI: idx_hi <= host_wdata[HI_W-1:0];
          default: ;
        endcase
      end
      if (host_rd) begin
        rd_from_ram <= (sel_e == REG_BITS);
        rd_filt     <= sel_f;
        case (sel_e)
          REG_IDX_LO: rd_reg <= idx_lo;
          REG_IDX_HI: rd_reg <= 8'(idx_hi);
          default:    rd_reg <= '0;
        endcase
      end
    end
  end

  assign host_rdata = rd_from_ram ? ram_q[int'(rd_filt)*8 +: 8] : rd_reg;
endmodule

// File: rtl/tspf_lane.sv
module tspf_lane
  import tspf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [7:0]       in_data,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_addr,
  input  logic [7:0]       rd_q,
  output logic             out_valid,
  output logic             out_sop,
  output logic [7:0]       out_data,
  output logic [CNT_W-1:0] resync_cnt,
  output logic             decide_evt,
  output logic             decide_low,
  output logic             decide_sync,
  output logic             keep
);
  // stages: byte0 capture, byte1 capture, table read, verdict latch
  localparam int LAT = 4;

  hdr_ph_e          ph;
  logic [7:0]       b1;
  logic             sync_ok;
  logic             pend;
  logic             keep_r;
  logic [PID_W-1:0] pid_r;
  logic [PID_W-1:0] pid_now;
  logic [CNT_W-1:0] res_q;
  logic             sop_evt;
  logic             hdr_evt;
  logic             verdict;
  logic [LAT-1:0]   v_q;
  logic [LAT-1:0]   s_q;
  logic [7:0]       d_q [LAT];

  assign sop_evt = in_valid && in_sop;
  assign hdr_evt = in_valid && !in_sop && (ph == PH_B2);
  assign pid_now = pid_from_hdr(b1, in_data);
  assign rd_en   = hdr_evt;
  assign rd_addr = pid_now[PID_W-1:BIT_W];
  assign verdict = sync_ok &&
                   (pid_always_pass(pid_r) || !bit_blocked(rd_q, pid_r[BIT_W-1:0]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      b1      <= '0;
      sync_ok <= 1'b0;
      pend    <= 1'b0;
      pid_r   <= '0;
      keep_r  <= 1'b0;
      res_q   <= '0;
    end else begin
      pend <= hdr_evt;
      if (hdr_evt) pid_r <= pid_now;
      if (pend) keep_r <= verdict;
      if (sop_evt) begin
        ph      <= PH_B1;
        sync_ok <= (in_data == SYNC_BYTE);
        if (in_data != SYNC_BYTE) res_q <= res_q + CNT_W'(1);
      end else if (in_valid && ph == PH_B1) begin
        b1 <= in_data;
        ph <= PH_B2;
      end else if (in_valid && ph == PH_B2) begin
        ph <= PH_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
      s_q <= '0;
      for (int i = 0; i < LAT; i++) d_q[i] <= '0;
    end else begin
      v_q    <= {v_q[LAT-2:0], in_valid};
      s_q    <= {s_q[LAT-2:0], sop_evt};
      d_q[0] <= in_data;
      for (int i = 1; i < LAT; i++) d_q[i] <= d_q[i-1];
    end
  end

  assign out_valid   = v_q[LAT-1] && keep_r;
  assign out_sop     = s_q[LAT-1] && out_valid;
  assign out_data    = d_q[LAT-1];
  assign resync_cnt  = res_q;
  assign decide_evt  = pend;
  assign decide_low  = pid_always_pass(pid_r);
  assign decide_sync = sync_ok;
  assign keep        = keep_r;
endmodule

// File: rtl/ts_pid_gate.sv
module ts_pid_gate
  import tspf_pkg::*;
#(
  parameter int NUM_FILT = 2,
  parameter int CNT_W    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      host_wr,
  input  logic                      host_rd,
  input  logic [1:0]                host_sel,
  input  logic [7:0]                host_wdata,
  output logic [7:0]                host_rdata,
  input  logic [NUM_FILT-1:0]       in_valid,
  input  logic [NUM_FILT-1:0]       in_sop,
  input  logic [NUM_FILT*8-1:0]     in_data,
  output logic [NUM_FILT-1:0]       out_valid,
  output logic [NUM_FILT-1:0]       out_sop,
  output logic [NUM_FILT*8-1:0]     out_data,
  output logic [NUM_FILT*CNT_W-1:0] resync_cnt
);
  localparam int FSEL_W = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1;

  logic [IDX_W-1:0]      h_addr;
  logic [7:0]            h_wdata;
  logic [NUM_FILT-1:0]   h_we;
  logic [NUM_FILT-1:0]   h_re;
  logic [NUM_FILT*8-1:0] h_q;
  logic [NUM_FILT-1:0]   dec_evt;
  logic [NUM_FILT-1:0]   dec_low;
  logic [NUM_FILT-1:0]   dec_sync;
  logic [NUM_FILT-1:0]   lane_keep;

  tspf_host #(.NUM_FILT(NUM_FILT), .FSEL_W(FSEL_W)) u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .ram_addr   (h_addr),
    .ram_wdata  (h_wdata),
    .ram_we     (h_we),
    .ram_re     (h_re),
    .ram_q      (h_q)
  );

  for (genvar g = 0; g < NUM_FILT; g++) begin : g_filt
    logic             s_re;
    logic [IDX_W-1:0] s_addr;
    logic [7:0]       s_q;

    tspf_bitmap_ram #(.IDX_W(IDX_W), .DW(8)) u_ram (
      .clk     (clk),
      .a_we    (h_we[g]),
      .a_re    (h_re[g]),
      .a_addr  (h_addr),
      .a_wdata (h_wdata),
      .a_q     (h_q[g*8 +: 8]),
      .b_re    (s_re),
      .b_addr  (s_addr),
      .b_q     (s_q)
    );

    tspf_lane #(.CNT_W(CNT_W)) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid[g]),
      .in_sop      (in_sop[g]),
      .in_data     (in_data[g*8 +: 8]),
      .rd_en       (s_re),
      .rd_addr     (s_addr),
      .rd_q        (s_q),
      .out_valid   (out_valid[g]),
      .out_sop     (out_sop[g]),
      .out_data    (out_data[g*8 +: 8]),
      .resync_cnt  (resync_cnt[g*CNT_W +: CNT_W]),
      .decide_evt  (dec_evt[g]),
      .decide_low  (dec_low[g]),
      .decide_sync (dec_sync[g]),
      .keep        (lane_keep[g])
    );
  end
endmodule

// File: rtl/ts_pid_gate_chk.sv
module ts_pid_gate_chk
  import tspf_pkg::*;
#(
  parameter int NUM_FILT = 2,
  parameter int CNT_W    = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_FILT-1:0]       in_valid,
  input logic [NUM_FILT-1:0]       in_sop,
  input logic [NUM_FILT*8-1:0]     in_data,
  input logic [NUM_FILT-1:0]       out_valid,
  input logic [NUM_FILT-1:0]       out_sop,
  input logic [NUM_FILT*8-1:0]     out_data,
  input logic [NUM_FILT*CNT_W-1:0] resync_cnt,
  input logic [NUM_FILT-1:0]       dec_evt,
  input logic [NUM_FILT-1:0]       dec_low,
  input logic [NUM_FILT-1:0]       dec_sync,
  input logic [NUM_FILT-1:0]       lane_keep
);
  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (out_valid == '0 && resync_cnt == '0));

  for (genvar g = 0; g < NUM_FILT; g++) begin : g_chk
    // R6
    latency_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[g] |-> ($past(in_valid[g], 4) &&
                        $past(in_data[g*8 +: 8], 4) == out_data[g*8 +: 8]));

    // R6
    sop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_sop[g] |-> out_valid[g]);

    // R5
    sop_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_sop[g] |-> (out_data[g*8 +: 8] == SYNC_BYTE));

    // R5
    resync_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[g] && in_sop[g] && in_data[g*8 +: 8] != SYNC_BYTE) |=>
        (resync_cnt[g*CNT_W +: CNT_W] == $past(resync_cnt[g*CNT_W +: CNT_W]) + CNT_W'(1)));

    // R5
    resync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid[g] && in_sop[g]) |=> $stable(resync_cnt[g*CNT_W +: CNT_W]));

    // R4
    low_pid_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_evt[g] && dec_low[g] && dec_sync[g]) |=> lane_keep[g]);
  end
endmodule

bind ts_pid_gate ts_pid_gate_chk #(.NUM_FILT(NUM_FILT), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_sop     (in_sop),
  .in_data    (in_data),
  .out_valid  (out_valid),
  .out_sop    (out_sop),
  .out_data   (out_data),
  .resync_cnt (resync_cnt),
  .dec_evt    (dec_evt),
  .dec_low    (dec_low),
  .dec_sync   (dec_sync),
  .lane_keep  (lane_keep)
);

// File: tb/test_ts_pid_gate.sv
`timescale 1ns/1ps
module test_ts_pid_gate;
  localparam int NF    = 2;
  localparam int CW    = 16;
  localparam int PKT   = 188;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            host_wr = 1'b0;
  logic            host_rd = 1'b0;
  logic [1:0]      host_sel = 2'd0;
  logic [7:0]      host_wdata = 8'd0;
  logic [7:0]      host_rdata;
  logic [NF-1:0]   in_valid = '0;
  logic [NF-1:0]   in_sop = '0;
  logic [NF*8-1:0] in_data = '0;
  logic [NF-1:0]   out_valid;
  logic [NF-1:0]   out_sop;
  logic [NF*8-1:0] out_data;
  logic [NF*CW-1:0] resync_cnt;

  always #2.5 clk = ~clk;

  ts_pid_gate #(.NUM_FILT(NF), .CNT_W(CW)) i_ts_pid_gate (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data),
    .resync_cnt(resync_cnt)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 0;
  logic [7:0] shadow [NF][1024];
  int  pool [NF][8];
  int  exp_res [NF];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected verdict restated from the requirements
  function automatic bit exp_keep(input int f, input logic [7:0] syn, input int pid);
    if (syn != 8'h47) return 1'b0;
    if (pid <= 31) return 1'b1;
    return ((shadow[f][pid / 8] >> (pid % 8)) & 8'd1) == 8'd0;
  endfunction

  task automatic reg_wr(input logic [1:0] sel, input logic [7:0] v);
    host_wr = 1'b1; host_sel = sel; host_wdata = v;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] sel, output logic [7:0] v);
    host_rd = 1'b1; host_sel = sel;
    @(posedge clk); #1;
    host_rd = 1'b0;
    v = host_rdata;
  endtask

  task automatic point(input int f, input int idx);
    reg_wr(2'd1, 8'((f << 2) | (idx >> 8)));
    reg_wr(2'd0, 8'(idx & 255));
  endtask

  task automatic set_byte(input int f, input int idx, input logic [7:0] v);
    point(f, idx);
    reg_wr(2'd2, v);
    shadow[f][idx] = v;
  endtask

  // read-modify-write of one table bit through the data register
  task automatic set_bit(input int f, input int pid, input bit val);
    logic [7:0] b;
    point(f, pid / 8);
    reg_rd(2'd2, b);
    chk(b == shadow[f][pid / 8], "R2", int'(b), int'(shadow[f][pid / 8]));
    if (val) b = b | 8'(1 << (pid % 8));
    else     b = b & ~8'(1 << (pid % 8));
    reg_wr(2'd2, b);
    shadow[f][pid / 8] = b;
  endtask

  task automatic run_traffic(input int npk);
    int pos [NF]; int gap [NF]; int left [NF]; int pid [NF];
    logic [7:0] syn [NF]; bit kp [NF];
    bit ev [NF][4]; bit es [NF][4]; logic [7:0] ed [NF][4];
    int c = 0; int idle_n = 0;
    for (int f = 0; f < NF; f++) begin
      pos[f] = -1; gap[f] = $urandom % 3; left[f] = npk; pid[f] = 0;
      syn[f] = 8'h47; kp[f] = 1'b0;
      for (int s = 0; s < 4; s++) begin ev[f][s] = 0; es[f][s] = 0; ed[f][s] = 0; end
    end
    while (idle_n < 6) begin
      for (int f = 0; f < NF; f++) begin
        int sl = c % 4;
        if (ev[f][sl] || out_valid[f])
          chk(out_valid[f] == ev[f][sl], "R3", int'(out_valid[f]), int'(ev[f][sl]));
        if (ev[f][sl] && out_valid[f]) begin
          chk(out_data[f*8 +: 8] == ed[f][sl], "R6", int'(out_data[f*8 +: 8]), int'(ed[f][sl]));
          chk(out_sop[f] == es[f][sl], "R6", int'(out_sop[f]), int'(es[f][sl]));
        end
      end
      for (int f = 0; f < NF; f++) begin
        int sl = c % 4;
        bit v = 0; bit s = 0; logic [7:0] d = 8'($urandom);
        if (pos[f] < 0) begin
          if (gap[f] > 0) gap[f]--;
          else if (left[f] > 0) begin
            int r = $urandom % 8;
            pid[f] = (r < 2) ? int'($urandom % 8192) : pool[f][r];
            syn[f] = ($urandom % 8 == 0) ? (8'h47 ^ 8'(1 << ($urandom % 8))) : 8'h47;
            if (syn[f] != 8'h47) exp_res[f]++;
            kp[f] = exp_keep(f, syn[f], pid[f]);
            pos[f] = 0;
          end
        end
        if (pos[f] >= 0 && !(pos[f] >= 3 && $urandom % 6 == 0)) begin
          v = 1;
          s = (pos[f] == 0);
          if (pos[f] == 0) d = syn[f];
          else if (pos[f] == 1) d = {3'($urandom), 5'(pid[f] >> 8)};
          else if (pos[f] == 2) d = 8'(pid[f] & 255);
          pos[f]++;
          if (pos[f] == PKT) begin
            pos[f] = -1; gap[f] = $urandom % 4; left[f]--;
          end
        end
        in_valid[f] = v; in_sop[f] = s; in_data[f*8 +: 8] = d;
        ev[f][sl] = v && kp[f]; es[f][sl] = s && kp[f]; ed[f][sl] = d;
      end
      if (left[0] == 0 && left[1] == 0 && pos[0] < 0 && pos[1] < 0) idle_n++;
      @(posedge clk); #1;
      c++;
    end
    for (int f = 0; f < NF; f++)
      chk(resync_cnt[f*CW +: CW] == CW'(exp_res[f]), "R5",
          int'(resync_cnt[f*CW +: CW]), exp_res[f]);
  endtask

  initial begin
    logic [7:0] rb;
    void'($urandom(32'd20240611));
    for (int f = 0; f < NF; f++) exp_res[f] = 0;
    repeat (5) @(posedge clk);
    #1;
    // R8 reset state
    chk(out_valid == '0, "R8", int'(out_valid), 0);
    chk(out_sop == '0, "R8", int'(out_sop), 0);
    chk(resync_cnt == '0, "R8", int'(resync_cnt), 0);
    chk(host_rdata == 8'd0, "R8", int'(host_rdata), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    reg_rd(2'd0, rb); chk(rb == 8'd0, "R8", int'(rb), 0);
    reg_rd(2'd1, rb); chk(rb == 8'd0, "R8", int'(rb), 0);

    // R1 index register readback
    reg_wr(2'd0, 8'hA5); reg_wr(2'd1, 8'hFF);
    reg_rd(2'd0, rb); chk(rb == 8'hA5, "R1", int'(rb), 'hA5);
    reg_rd(2'd1, rb); chk(rb == 8'h07, "R1", int'(rb), 'h07);

    // clear both tables (full-stream setup)
    for (int f = 0; f < NF; f++)
      for (int i = 0; i < 1024; i++) set_byte(f, i, 8'h00);

    // R2 data write and readback, top boundary index, R7 isolation
    set_byte(1, 'h155, 8'h3C);
    set_byte(0, 'h3FF, 8'h81);
    point(1, 'h155); reg_rd(2'd2, rb); chk(rb == 8'h3C, "R2", int'(rb), 'h3C);
    point(0, 'h3FF); reg_rd(2'd2, rb); chk(rb == 8'h81, "R2", int'(rb), 'h81);
    point(0, 'h155); reg_rd(2'd2, rb); chk(rb == 8'h00, "R7", int'(rb), 0);
    set_bit(1, 'h155 * 8 + 0, 1'b1);
    point(1, 'h155); reg_rd(2'd2, rb); chk(rb == 8'h3D, "R2", int'(rb), 'h3D);
    set_byte(1, 'h155, 8'h00);
    set_byte(0, 'h3FF, 8'h00);

    // traffic on a clear table: everything well formed passes (R3)
    for (int f = 0; f < NF; f++) begin
      pool[f][0] = 17;
      for (int k = 1; k < 8; k++) pool[f][k] = 32 + int'($urandom % 8160);
    end
    run_traffic(12);

    // directed: bit index, lane isolation (R3, R7), low PIDs (R4)
    set_bit(0, 'h1ABC, 1'b1);
    set_bit(1, 'h1ABD, 1'b1);
    for (int i = 0; i < 4; i++) set_byte(0, i, 8'hFF);
    for (int f = 0; f < NF; f++) begin
      pool[f][0] = 17; pool[f][1] = 0; pool[f][2] = 31;
      for (int k = 3; k < 8; k++) pool[f][k] = (k % 2 == 1) ? 'h1ABC : 'h1ABD;
    end
    run_traffic(16);

    // random table contents around a random PID pool (R3)
    for (int f = 0; f < NF; f++)
      for (int k = 1; k < 8; k++) begin
        pool[f][k] = 32 + int'($urandom % 8160);
        set_byte(f, pool[f][k] / 8, 8'($urandom));
      end
    run_traffic(24);

    // block-all mode on filter 1: only low PIDs pass (R4, R7)
    for (int i = 4; i < 1024; i++) set_byte(1, i, 8'hFF);
    for (int f = 0; f < NF; f++) pool[f][2] = 5;
    run_traffic(12);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule